// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit sits next to an 8-bit microcontroller core and watches two kinds of core activity. The first is instruction fetch addresses. The second is data accesses to internal data memory, external data memory and the special-function register space. It holds a bank of identical comparators. A comparator set to code space acts as a breakpoint on a fetch address. A comparator set to one of the three data spaces acts as a watchpoint. A watchpoint can be limited to reads, to writes or to both, and can optionally require one data byte. When any enabled comparator fires, the unit records which one fired in a sticky status register. It then stops the core at the next instruction boundary.

A host reaches the unit through a simple register port with single-cycle write and read strobes. Through this port it enables a debug session, programs the comparators, clears hit status and issues run-control commands. The commands are halt, run, step one instruction, and skip one instruction. A skip lets the core pass over an instruction while it suppresses that instruction's effects. Two status outputs report whether the core is executing and whether a host access is taking place. While no session is enabled, the unit sits in a low-power idle state: the comparators are gated off and the core runs freely.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset, core_hold=0, core_skip=0, code_run=1, dbg_idle=1, dbg_access=0, and the hit status register reads 0.
- R2: Host register map (4-bit address, 32-bit data). Address 0 is control: bit 0 is session enable. Address 1 takes a command in bits [1:0] (0 halt, 1 run, 2 step, 3 skip). A read of address 1 returns the run state (0 running, 1 halted, 2 stepping, 3 skipping). Address 2 is hit status, with one bit per comparator. Address 4+i is comparator i, which reads back exactly as written. Each host read returns its data on host_rdata after the next clock edge.
- R3: While session enable is 0, dbg_idle=1 and no comparator records a hit. Within two cycles of the session being cleared, the core is released (core_hold=0).
- R4: A comparator with space field [25:24]=0 (code) matches when fetch_vld is high and fetch_addr equals its address field [15:0]. Its access-type and data-compare fields are ignored.
- R5: A comparator with space 1 (internal data), 2 (external data) or 3 (SFR) matches only on a mem_vld access that meets all of these conditions: the access is in that same space, it is at the comparator's address, and its access type is permitted (bit 26 allows reads, bit 27 allows writes).
- R6: When data-compare enable (bit 28) is set, a data-space comparator also needs mem_data to equal its data field [23:16]. When bit 28 is clear, the data is ignored.
- R7: A hit sets the comparator's status bit. The bit stays set until the host writes 1 to it at address 2.
- R8: From the running state, a halt is taken only in a cycle with instr_done high. The halt can come from a hit seen in that cycle or earlier, or from a halt command. The core is held after that edge.
- R9: While halted, core_hold=1 and code_run=0. A run command releases the core on the next edge.
- R10: A step command issued while halted releases the core (core_hold=0, core_skip=0) until one instr_done, then halts again.
- R11: A skip command issued while halted raises core_skip with core_hold=0 until one instr_done, then halts with core_skip=0.
- R12: Step and skip commands have no effect while the core is running.
- R13: dbg_access is high for the cycle after each host read or write, and low otherwise.
- R14: A comparator whose enable bit (29) is 0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Core is fetching from fetch_addr this cycle |
| fetch_addr | input | 16 | Program fetch address |
| instr_done | input | 1 | Core is at an instruction boundary this cycle |
| mem_vld | input | 1 | Core data access this cycle |
| mem_space | input | 2 | Access space: 1 internal, 2 external, 3 SFR |
| mem_wr | input | 1 | 1 for write, 0 for read |
| mem_addr | input | 16 | Data access address |
| mem_data | input | 8 | Data written or read |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| core_hold | output | 1 | Core must not start another instruction |
| core_skip | output | 1 | Core must not commit the current instruction |
| code_run | output | 1 | Core is executing |
| dbg_access | output | 1 | Host access in progress |
| dbg_idle | output | 1 | No debug session, unit idle |

## Verification
The bench attacks the timing of the halt. It delivers a hit several cycles before the boundary and checks that the core keeps running until instr_done. A design that stopped the core mid-instruction, or dropped a hit that arrived between boundaries, would fail here. It sends watchpoint accesses that differ from the programmed one in only one respect each: a wrong data byte, a read against a write-only watch, or the right address in the wrong space. A comparator that ignored its type, data or space field would halt the core where it must not. The bench also issues a step while the core is running, sends a halt without a boundary, and clears the session while the core is held. A design that honoured the stray step, halted early, or left the core frozen with the session off would give a wrong hold or state readback.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
    localparam int CORE_AW = 16;
    localparam int CORE_DW = 8;
    localparam int HOST_AW = 4;
    localparam int HOST_DW = 32;

    localparam logic [HOST_AW-1:0] RA_CTRL = 4'd0;
    localparam logic [HOST_AW-1:0] RA_CMD  = 4'd1;
    localparam logic [HOST_AW-1:0] RA_STAT = 4'd2;
    localparam int                 RA_CMP_BASE = 4;

    typedef enum logic [1:0] {
        SP_CODE  = 2'd0,
        SP_IDATA = 2'd1,
        SP_XDATA = 2'd2,
        SP_SFR   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        CMD_HALT = 2'd0,
        CMD_RUN  = 2'd1,
        CMD_STEP = 2'd2,
        CMD_SKIP = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        RC_RUN  = 2'd0,
        RC_HALT = 2'd1,
        RC_STEP = 2'd2,
        RC_SKIP = 2'd3
    } rc_state_e;

    typedef struct packed {
        logic               en;
        logic               dce;
        logic               acc_wr;
        logic               acc_rd;
        space_e             space;
        logic [CORE_DW-1:0] data;
        logic [CORE_AW-1:0] addr;
    } cmp_cfg_t;

    localparam int CFG_W = $bits(cmp_cfg_t);
endpackage

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
    import dbg_trap_pkg::*;
#(
    parameter int NCMP = 4
) (
    input  cmp_cfg_t [NCMP-1:0] cfg_i,
    input  logic                sess_en_i,
    input  logic                fetch_vld_i,
    input  logic [CORE_AW-1:0]  fetch_addr_i,
    input  logic                mem_vld_i,
    input  logic [1:0]          mem_space_i,
    input  logic                mem_wr_i,
    input  logic [CORE_AW-1:0]  mem_addr_i,
    input  logic [CORE_DW-1:0]  mem_data_i,
    output logic [NCMP-1:0]     hit_o
);
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        logic is_code;
        logic code_hit;
        logic space_ok;
        logic type_ok;
        logic data_ok;
        logic data_hit;

        assign is_code  = (cfg_i[g].space == SP_CODE);
        assign code_hit = is_code && fetch_vld_i
                          && (fetch_addr_i == cfg_i[g].addr);
        assign space_ok = !is_code && (mem_space_i == cfg_i[g].space);
        assign type_ok  = mem_wr_i ? cfg_i[g].acc_wr : cfg_i[g].acc_rd;
        assign data_ok  = !cfg_i[g].dce || (mem_data_i == cfg_i[g].data);
        assign data_hit = mem_vld_i && space_ok && type_ok && data_ok
                          && (mem_addr_i == cfg_i[g].addr);
        assign hit_o[g] = sess_en_i && cfg_i[g].en && (code_hit || data_hit);
    end
endmodule

// File: rtl/dbg_host_regs.sv
module dbg_host_regs
    import dbg_trap_pkg::*;
#(
    parameter int NCMP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr_i,
    input  logic                host_rd_i,
    input  logic [HOST_AW-1:0]  host_addr_i,
    input  logic [HOST_DW-1:0]  host_wdata_i,
    input  logic [NCMP-1:0]     hit_i,
    input  rc_state_e           state_i,
    output logic [HOST_DW-1:0]  host_rdata_o,
    output logic                access_o,
    output logic                sess_en_o,
    output logic                cmd_vld_o,
    output cmd_e                cmd_o,
    output cmp_cfg_t [NCMP-1:0] cfg_o
);
    typedef struct packed {
        logic                sess_en;
        cmp_cfg_t [NCMP-1:0] cfg;
        logic [NCMP-1:0]     status;
        logic [HOST_DW-1:0]  rdata;
        logic                access;
    } regs_t;

    regs_t q, d;

    logic unused_wbits;
    assign unused_wbits = ^host_wdata_i[HOST_DW-1:CFG_W];

    always_comb begin
        d        = q;
        d.access = host_wr_i || host_rd_i;
        d.status = q.status | hit_i;
        if (host_wr_i) begin
            if (host_addr_i == RA_CTRL) d.sess_en = host_wdata_i[0];
            if (host_addr_i == RA_STAT)
                d.status = (q.status & ~host_wdata_i[NCMP-1:0]) | hit_i;
            for (int i = 0; i < NCMP; i++) begin
                if (host_addr_i == HOST_AW'(RA_CMP_BASE + i))
                    d.cfg[i] = cmp_cfg_t'(host_wdata_i[CFG_W-1:0]);
            end
        end
        if (host_rd_i) begin
            d.rdata = '0;
            case (host_addr_i)
                RA_CTRL: d.rdata[0]        = q.sess_en;
                RA_CMD:  d.rdata[1:0]      = state_i;
                RA_STAT: d.rdata[NCMP-1:0] = q.status;
                default: begin
                    for (int i = 0; i < NCMP; i++) begin
                        if (host_addr_i == HOST_AW'(RA_CMP_BASE + i))
                            d.rdata[CFG_W-1:0] = q.cfg[i];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata_o = q.rdata;
    assign access_o     = q.access;
    assign sess_en_o    = q.sess_en;
    assign cfg_o        = q.cfg;
    assign cmd_vld_o    = host_wr_i && (host_addr_i == RA_CMD);
    assign cmd_o        = cmd_e'(host_wdata_i[1:0]);

    for (genvar g = 0; g < NCMP; g++) begin : g_sticky
        // R7
        sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(q.status[g]) && !($past(host_wr_i)
              && ($past(host_addr_i) == RA_STAT) && $past(host_wdata_i[g])))
            |-> q.status[g]);
    end
endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
    import dbg_trap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sess_en_i,
    input  logic      cmd_vld_i,
    input  cmd_e      cmd_i,
    input  logic      hit_any_i,
    input  logic      instr_done_i,
    output logic      core_hold_o,
    output logic      core_skip_o,
    output logic      code_run_o,
    output rc_state_e state_o
);
    typedef struct packed {
        rc_state_e st;
        logic      halt_req;
    } rc_t;

    rc_t q, d;
    logic halt_cmd;

    assign halt_cmd = cmd_vld_i && (cmd_i == CMD_HALT);

    always_comb begin
        d = q;
        case (q.st)
            RC_RUN: begin
                if (halt_cmd || hit_any_i) d.halt_req = 1'b1;
                if (instr_done_i && (q.halt_req || halt_cmd || hit_any_i)) begin
                    d.st       = RC_HALT;
                    d.halt_req = 1'b0;
                end
            end
            RC_HALT: begin
                d.halt_req = 1'b0;
                if (cmd_vld_i) begin
                    case (cmd_i)
                        CMD_RUN:  d.st = RC_RUN;
                        CMD_STEP: d.st = RC_STEP;
                        CMD_SKIP: d.st = RC_SKIP;
                        default:  d.st = RC_HALT;
                    endcase
                end
            end
            default: begin
                d.halt_req = 1'b0;
                if (instr_done_i) d.st = RC_HALT;
            end
        endcase
        if (!sess_en_i) begin
            d.st       = RC_RUN;
            d.halt_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RC_RUN, halt_req: 1'b0};
        else        q <= d;
    end

    assign core_hold_o = (q.st == RC_HALT);
    assign core_skip_o = (q.st == RC_SKIP);
    assign code_run_o  = (q.st != RC_HALT);
    assign state_o     = q.st;

    // R8
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RC_RUN && !instr_done_i) |=> !core_hold_o);
    // R10
    step_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RC_STEP && instr_done_i && sess_en_i) |=> core_hold_o);
    // R11
    skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_skip_o |-> (!core_hold_o && code_run_o));
    // R3
    sess_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sess_en_i && !$past(sess_en_i)) |-> !core_hold_o);
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
    import dbg_trap_pkg::*;
#(
    parameter int NCMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_vld,
    input  logic [CORE_AW-1:0] fetch_addr,
    input  logic               instr_done,
    input  logic               mem_vld,
    input  logic [1:0]         mem_space,
    input  logic               mem_wr,
    input  logic [CORE_AW-1:0] mem_addr,
    input  logic [CORE_DW-1:0] mem_data,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               core_hold,
    output logic               core_skip,
    output logic               code_run,
    output logic               dbg_access,
    output logic               dbg_idle
);
    localparam int MAX_CMP = (1 << HOST_AW) - RA_CMP_BASE;
    localparam int NCMP_OK = (NCMP < 1) ? 1 : ((NCMP > MAX_CMP) ? MAX_CMP : NCMP);

    cmp_cfg_t [NCMP_OK-1:0] cfg;
    logic [NCMP_OK-1:0]     hit_vec;
    logic                   sess_en;
    logic                   cmd_vld;
    cmd_e                   cmd;
    rc_state_e              rc_state;

    dbg_host_regs #(.NCMP(NCMP_OK)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr),
        .host_rd_i    (host_rd),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .hit_i        (hit_vec),
        .state_i      (rc_state),
        .host_rdata_o (host_rdata),
        .access_o     (dbg_access),
        .sess_en_o    (sess_en),
        .cmd_vld_o    (cmd_vld),
        .cmd_o        (cmd),
        .cfg_o        (cfg)
    );

    dbg_cmp_bank #(.NCMP(NCMP_OK)) u_cmp (
        .cfg_i        (cfg),
        .sess_en_i    (sess_en),
        .fetch_vld_i  (fetch_vld),
        .fetch_addr_i (fetch_addr),
        .mem_vld_i    (mem_vld),
        .mem_space_i  (mem_space),
        .mem_wr_i     (mem_wr),
        .mem_addr_i   (mem_addr),
        .mem_data_i   (mem_data),
        .hit_o        (hit_vec)
    );

    dbg_run_ctl u_rc (
        .clk          (clk),
        .rst_n        (rst_n),
        .sess_en_i    (sess_en),
        .cmd_vld_i    (cmd_vld),
        .cmd_i        (cmd),
        .hit_any_i    (|hit_vec),
        .instr_done_i (instr_done),
        .core_hold_o  (core_hold),
        .core_skip_o  (core_skip),
        .code_run_o   (code_run),
        .state_o      (rc_state)
    );

    assign dbg_idle = !sess_en;
endmodule

// File: tb/dbg_trap_unit_test.sv
`timescale 1ns/1ps
module dbg_trap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 0, instr_done = 0, mem_vld = 0, mem_wr = 0;
    logic [15:0] fetch_addr = '0, mem_addr = '0;
    logic [1:0]  mem_space = '0;
    logic [7:0]  mem_data = '0;
    logic        host_wr = 0, host_rd = 0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        core_hold, core_skip, code_run, dbg_access, dbg_idle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    string       tag_q[$];
    int          probe_q[$];
    logic [31:0] val_q[$];

    localparam int P_HOLD = 0, P_SKIP = 1, P_RUN = 2, P_ACC = 3, P_IDLE = 4, P_RD = 5;

    always #2.5 clk = ~clk;

    dbg_trap_unit uut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .instr_done(instr_done), .mem_vld(mem_vld), .mem_space(mem_space),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .core_hold(core_hold),
        .core_skip(core_skip), .code_run(code_run), .dbg_access(dbg_access),
        .dbg_idle(dbg_idle)
    );

    function automatic logic [31:0] probe(int p);
        case (p)
            P_HOLD:  return {31'b0, core_hold};
            P_SKIP:  return {31'b0, core_skip};
            P_RUN:   return {31'b0, code_run};
            P_ACC:   return {31'b0, dbg_access};
            P_IDLE:  return {31'b0, dbg_idle};
            default: return host_rdata;
        endcase
    endfunction

    // Monitor: checks every expectation queued for the edge just passed.
    always @(posedge clk) begin
        #1;
        while (probe_q.size() > 0) begin
            string       t;
            int          p;
            logic [31:0] v;
            logic [31:0] a;
            t = tag_q.pop_front();
            p = probe_q.pop_front();
            v = val_q.pop_front();
            a = probe(p);
            n_checks++;
            if (a !== v) begin
                n_fail++;
                $display("FAIL %s probe=%0d actual=%h expected=%h", t, p, a, v);
            end
        end
    end

    task automatic push_exp(string t, int p, logic [31:0] v);
        tag_q.push_back(t);
        probe_q.push_back(p);
        val_q.push_back(v);
    endtask

    task automatic nxt();
        @(negedge clk);
        host_wr = 0; host_rd = 0; instr_done = 0;
        fetch_vld = 0; mem_vld = 0; mem_wr = 0;
    endtask

    task automatic hw(logic [3:0] a, logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        nxt();
    endtask

    task automatic hr(string t, logic [3:0] a, logic [31:0] e);
        host_rd = 1; host_addr = a;
        push_exp(t, P_RD, e);
        nxt();
    endtask

    task automatic fetch(logic [15:0] a, logic dn);
        fetch_vld = 1; fetch_addr = a; instr_done = dn;
        nxt();
    endtask

    task automatic mem(logic [1:0] sp, logic wr, logic [15:0] a, logic [7:0] d, logic dn);
        mem_vld = 1; mem_space = sp; mem_wr = wr; mem_addr = a; mem_data = d;
        instr_done = dn;
        nxt();
    endtask

    task automatic boundary();
        instr_done = 1;
        nxt();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        push_exp("R1", P_HOLD, 0); push_exp("R1", P_SKIP, 0);
        push_exp("R1", P_RUN, 1);  push_exp("R1", P_IDLE, 1);
        push_exp("R1", P_ACC, 0);
        nxt();
        hr("R1", 4'd2, 32'h0);
        // R3 / R13 session enable and access flag
        push_exp("R3", P_IDLE, 0); push_exp("R13", P_ACC, 1);
        hw(4'd0, 32'h1);
        hr("R2", 4'd0, 32'h1);
        hw(4'd4, 32'h2000_0123);
        hw(4'd5, 32'h3A5A_0400);
        hw(4'd6, 32'h2D00_0030);
        hw(4'd7, 32'h0F00_0010);
        hr("R2", 4'd5, 32'h3A5A_0400);
        push_exp("R13", P_ACC, 0);
        nxt();
        // R4 / R8 breakpoint, halt only at boundary
        push_exp("R4", P_HOLD, 0);
        fetch(16'h0120, 1);
        push_exp("R8", P_HOLD, 0);
        fetch(16'h0123, 0);
        push_exp("R8", P_HOLD, 1); push_exp("R9", P_RUN, 0);
        boundary();
        hr("R7", 4'd2, 32'h1);
        // R10 step
        push_exp("R10", P_HOLD, 0); push_exp("R10", P_RUN, 1); push_exp("R10", P_SKIP, 0);
        hw(4'd1, 32'h2);
        push_exp("R10", P_HOLD, 0);
        nxt();
        push_exp("R10", P_HOLD, 1);
        boundary();
        // R11 skip
        push_exp("R11", P_SKIP, 1); push_exp("R11", P_HOLD, 0);
        hw(4'd1, 32'h3);
        push_exp("R11", P_SKIP, 0); push_exp("R11", P_HOLD, 1);
        boundary();
        hr("R2", 4'd1, 32'h1);
        // R7 clear by writing one
        hw(4'd2, 32'hF);
        hr("R7", 4'd2, 32'h0);
        // R9 run; R5 / R6 external-data write watch with data
        push_exp("R9", P_HOLD, 0); push_exp("R9", P_RUN, 1);
        hw(4'd1, 32'h1);
        push_exp("R6", P_HOLD, 0);
        mem(2'd2, 1, 16'h0400, 8'h11, 1);
        push_exp("R5", P_HOLD, 0);
        mem(2'd2, 0, 16'h0400, 8'h5A, 1);
        push_exp("R6", P_HOLD, 1);
        mem(2'd2, 1, 16'h0400, 8'h5A, 1);
        hr("R6", 4'd2, 32'h2);
        hw(4'd2, 32'hF);
        // R5 internal-data watch, data ignored, wrong space first
        push_exp("R9", P_HOLD, 0);
        hw(4'd1, 32'h1);
        push_exp("R5", P_HOLD, 0);
        mem(2'd3, 0, 16'h0030, 8'h99, 1);
        push_exp("R5", P_HOLD, 1);
        mem(2'd1, 0, 16'h0030, 8'h77, 1);
        hr("R5", 4'd2, 32'h4);
        hw(4'd2, 32'hF);
        // R8 host halt waits for boundary
        hw(4'd1, 32'h1);
        push_exp("R8", P_HOLD, 0);
        hw(4'd1, 32'h0);
        push_exp("R8", P_HOLD, 0);
        nxt();
        push_exp("R8", P_HOLD, 1);
        boundary();
        // R12 step ignored while running
        push_exp("R12", P_HOLD, 0);
        hw(4'd1, 32'h1);
        push_exp("R12", P_HOLD, 0); push_exp("R12", P_SKIP, 0);
        hw(4'd1, 32'h2);
        push_exp("R12", P_HOLD, 0);
        boundary();
        hr("R12", 4'd1, 32'h0);
        // R14 disabled comparator
        push_exp("R14", P_HOLD, 0);
        mem(2'd3, 1, 16'h0010, 8'h00, 1);
        hr("R14", 4'd2, 32'h0);
        // R3 session off releases a held core and gates comparators
        hw(4'd1, 32'h0);
        push_exp("R3", P_HOLD, 1);
        boundary();
        push_exp("R3", P_IDLE, 1);
        hw(4'd0, 32'h0);
        push_exp("R3", P_HOLD, 0);
        nxt();
        push_exp("R3", P_HOLD, 0);
        fetch(16'h0123, 1);
        hr("R3", 4'd2, 32'h0);
        hr("R3", 4'd1, 32'h0);
        nxt();
        nxt();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule